// File: doc/BRIEF.md
# Multi-Operation 32-bit ALU

This block is a purely combinational arithmetic-logic unit for a simple processor datapath. It takes two operands and a three-bit operation code. It returns the operation result, a flag that is high when every result bit is clear, and a signed overflow flag. The operations are bitwise AND, bitwise OR, addition, subtraction and a signed set-on-less-than compare.

One adder serves addition, subtraction and the compare. Bit 2 of the operation code inverts the second operand and also supplies the adder's carry-in, so the adder forms A + ~B + 1 = A − B. The compare takes the sign of that difference and corrects it with the overflow condition, so it stays right even when the subtraction wraps. The unit has no registers. A caller drives the operands and the code and reads the outputs in the same cycle.

Top module: `aluTop`

## Requirements
- R1: With operation code 3'b000 the result is the bitwise AND of the two operands.
- R2: With operation code 3'b001 the result is the bitwise OR of the two operands.
- R3: With operation code 3'b010 the result is A + B modulo 2^32.
- R4: With operation code 3'b110 the result is A − B modulo 2^32.
- R5: With operation code 3'b111 the result is 32'd1 when A is less than B, both read as two's-complement signed values, and 32'd0 otherwise. This holds even when A − B overflows.
- R6: The zero output is 1 exactly when all 32 result bits are 0, for every operation code.
- R7: With code 3'b010 the overflow output is 1 exactly when the true signed sum lies outside [−2^31, 2^31−1].
- R8: With code 3'b110 the overflow output is 1 exactly when the true signed difference lies outside [−2^31, 2^31−1].
- R9: With codes 3'b000, 3'b001 and 3'b111 the overflow output is 0.
- R10: With the unused codes 3'b011, 3'b100 and 3'b101 the result is 0 and the overflow output is 0, so the zero output is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opSel | input | 3 | Operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | High when every result bit is 0 |
| overflow | output | 1 | Signed overflow of add or subtract |

## Verification
All three outputs are combinational, so each one is due in the same cycle as the operands and code that produce it, with no register delay. The bench applies each new vector just after a falling clock edge. It then waits a short fixed delay inside the same low phase before it compares result, zero and overflow against values it computes with 64-bit signed arithmetic. Each vector is therefore checked once it has settled and before the next vector is applied. All eight codes are swept against every pair from a set of boundary operands (most-negative, most-positive, their neighbours, zero, all-ones). Random operand pairs follow for each operation.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } aluOp_e;

  // Strobes from the decoder to the datapath.
  typedef struct packed {
    logic invertB;    // invert operand B and force adder carry-in
    logic selAnd;     // route AND to result
    logic selOr;      // route OR to result
    logic selSum;     // route adder output to result
    logic selSlt;     // route compare bit to result
    logic ovfEnable;  // allow overflow flag out
  } aluStrobes_t;

endpackage

// File: rtl/aluControl.sv
module aluControl
  import alu_pkg::*;
(
  input  logic [2:0]  opSel,
  output aluStrobes_t strobes
);

  always_comb begin
    strobes         = '0;
    // bit 2 of the code is the shared invert / carry-in control
    strobes.invertB = opSel[2];
    case (opSel)
      OP_AND: strobes.selAnd = 1'b1;
      OP_OR:  strobes.selOr  = 1'b1;
      OP_ADD: begin
        strobes.selSum    = 1'b1;
        strobes.ovfEnable = 1'b1;
      end
      OP_SUB: begin
        strobes.selSum    = 1'b1;
        strobes.ovfEnable = 1'b1;
      end
      OP_SLT: strobes.selSlt = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    AST_ROUTE_ONEHOT: assert ($onehot0({strobes.selAnd, strobes.selOr,
                                        strobes.selSum, strobes.selSlt})); // R10
    AST_OVF_ONLY_ARITH: assert (!strobes.ovfEnable || strobes.selSum); // R9
    AST_COMPARE_SUBTRACTS: assert (!strobes.selSlt || strobes.invertB); // R5
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  aluStrobes_t       strobes,
  output logic [DATA_W-1:0] result,
  output logic              zero,
  output logic              overflow
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] bEff;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] carryIn;
  logic              ovfRaw;
  logic              lessThan;

  assign bEff    = opB ^ {DATA_W{strobes.invertB}};
  assign carryIn = {{(DATA_W-1){1'b0}}, strobes.invertB};
  assign sum     = opA + bEff + carryIn;

  // Signed overflow: operands of equal sign, result of the other sign.
  assign ovfRaw   = (opA[MSB] == bEff[MSB]) && (sum[MSB] != opA[MSB]);
  // Sign of A-B, corrected when the difference wrapped.
  assign lessThan = sum[MSB] ^ ovfRaw;

  always_comb begin
    result = '0;
    if (strobes.selAnd) result = opA & opB;
    if (strobes.selOr)  result = opA | opB;
    if (strobes.selSum) result = sum;
    if (strobes.selSlt) result = {{(DATA_W-1){1'b0}}, lessThan};
  end

  assign zero     = ~|result;
  assign overflow = ovfRaw & strobes.ovfEnable;

  always_comb begin
    AST_NO_OVERFLOW: assert (strobes.ovfEnable || !overflow); // R9
    AST_SLT_SINGLE_BIT: assert (!strobes.selSlt || result[MSB:1] == '0); // R5
    AST_IDLE_RESULT: assert ((strobes.selAnd || strobes.selOr || strobes.selSum
                              || strobes.selSlt) || result == '0); // R10
  end

endmodule

// File: rtl/aluTop.sv
module aluTop
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [2:0]        opSel,
  output logic [DATA_W-1:0] result,
  output logic              zero,
  output logic              overflow
);

  aluStrobes_t strobes;

  aluControl u_control (
    .opSel   (opSel),
    .strobes (strobes)
  );

  aluDatapath #(.DATA_W(DATA_W)) u_datapath (
    .opA      (opA),
    .opB      (opB),
    .strobes  (strobes),
    .result   (result),
    .zero     (zero),
    .overflow (overflow)
  );

  always_comb begin
    AST_ZERO_MEANS_CLEAR: assert (!zero || result == '0); // R6
    AST_LOGIC_NO_OVF: assert (!(opSel == 3'b000 || opSel == 3'b001) || !overflow); // R9
  end

endmodule

// File: tb/sim_aluTop.sv
module sim_aluTop;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [2:0]  opSel = '0;
  logic [31:0] result;
  logic        zero;
  logic        overflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;  // 100 MHz

  aluTop u0 (
    .opA      (opA),
    .opB      (opB),
    .opSel    (opSel),
    .result   (result),
    .zero     (zero),
    .overflow (overflow)
  );

  function automatic logic [31:0] cornerVal(input int idx);
    case (idx)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      5: return 32'h8000_0001;
      6: return 32'h7FFF_FFFE;
      default: return 32'h1234_5678;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (sel=%b a=%h b=%h)",
               req, what, act, exp, opSel, opA, opB);
    end
  endtask

  task automatic applyAndCheck(input logic [2:0] sel, input logic [31:0] a,
                               input logic [31:0] b);
    longint sa;
    longint sb;
    longint wide;
    logic [31:0] expR;
    logic        expV;
    string       rTag;
    string       vTag;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    expR = '0;
    expV = 1'b0;
    vTag = "R9";
    case (sel)
      3'b000: begin expR = a & b; rTag = "R1"; end
      3'b001: begin expR = a | b; rTag = "R2"; end
      3'b010: begin
        wide = sa + sb; expR = wide[31:0]; rTag = "R3"; vTag = "R7";
        expV = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
      end
      3'b110: begin
        wide = sa - sb; expR = wide[31:0]; rTag = "R4"; vTag = "R8";
        expV = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
      end
      3'b111: begin expR = (sa < sb) ? 32'd1 : 32'd0; rTag = "R5"; end
      default: begin expR = '0; rTag = "R10"; vTag = "R10"; end
    endcase
    @(negedge clk);
    opSel = sel;
    opA   = a;
    opB   = b;
    #2;  // combinational: due in the same cycle
    check(rTag, "result", result, expR);
    check("R6", "zero", {31'd0, zero}, {31'd0, (expR == 32'd0)});
    check(vTag, "overflow", {31'd0, overflow}, {31'd0, expV});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // idle state: all-zero inputs select AND of zeros
    #2;
    check("R1", "idle result", result, 32'd0);
    check("R6", "idle zero", {31'd0, zero}, 32'd1);
    // exhaustive code sweep over boundary operand pairs
    for (int s = 0; s < 8; s++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          applyAndCheck(3'(s), cornerVal(i), cornerVal(j));
    // explicit overflow and compare corners
    applyAndCheck(3'b010, 32'h7FFF_FFFF, 32'h0000_0001); // R7 positive wrap
    applyAndCheck(3'b110, 32'h8000_0000, 32'h0000_0001); // R8 negative wrap
    applyAndCheck(3'b111, 32'h8000_0000, 32'h7FFF_FFFF); // R5 with wrapped difference
    applyAndCheck(3'b111, 32'h7FFF_FFFF, 32'h8000_0000); // R5
    applyAndCheck(3'b110, 32'hDEAD_BEEF, 32'hDEAD_BEEF); // R4 equal operands, R6
    // random operands per code
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 300; k++)
        applyAndCheck(3'(s), $urandom, $urandom);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule